// File: doc/BRIEF.md
# Time-Triggered Slot Sequencer

This block is the timing core of a node on a shared broadcast bus that uses time-division access. A free-running global time counter advances every clock. Time is divided into rounds of fixed length. Each round holds one slot for every node, in the same order and at the same offsets in every round. A configurable number of rounds forms a cycle, and the cycle repeats without end. The sequencer walks a preloaded schedule table with one entry for each slot of each round. When the time within the round reaches the instant stored in the current entry, the block emits a one-cycle transmit-start or receive-start pulse. The pulse carries the entry's buffer address and frame length toward the message buffer.

Table entries are written through a simple write port, normally while the block is held in reset. Only the slot that belongs to the local node may start a transmission. An entry flagged as receive starts a reception in any slot. A transmit entry with zero length leaves the slot empty. Inconsistent entries raise a sticky configuration-error flag: a length above the payload limit, or an instant that is not later than the previous instant in the same round. The block also divides the global time down into a periodic tick for the host processor.

Top module: `tdma_sequencer`

## Requirements
- R1: While reset is asserted, tx_start, rx_start, tick, cfg_err, global_time and every cmd_* output read zero.
- R2: global_time is 1 after the first clock edge following reset release and increases by exactly one on every clock edge after that.
- R3: tick is a one-cycle pulse that is high exactly when global_time is a nonzero multiple of TICK_DIV.
- R4: Each round lasts ROUND_LEN cycles. Round r of the cycle starts at round time 0. The entry for slot s of round r produces its pulse in the cycle where global_time equals (cycle start) + r*ROUND_LEN + at + 1.
- R5: cfg_rounds selects the rounds per cycle: 0 selects 2, 1 selects 4, 2 selects 8 and 3 selects 16, with a ceiling of MAX_ROUNDS. After the last round, the round index returns to 0.
- R6: The last round of a cycle is followed directly by round 0. When the last slot sits at round time ROUND_LEN-1 and slot 0 sits at time 0, their pulses fall in consecutive cycles.
- R7: An entry with its receive bit (bit 24) set produces rx_start, never tx_start, whichever slot it occupies.
- R8: An entry with the receive bit clear produces tx_start only in slot local_slot. In any other slot it produces no pulse.
- R9: A local transmit entry with length field (bits 5:0) equal to 0 produces no tx_start, and the slot and round sequence continue unchanged.
- R10: A local transmit entry with a length above 32 produces no tx_start and sets cfg_err.
- R11: If an entry's instant field (bits 23:16) is not greater than the instant of the last accepted entry of the same round, the entry is skipped without a pulse and cfg_err is set.
- R12: With each pulse, cmd_addr (entry bits 15:6), cmd_len, cmd_round and cmd_slot carry the entry's values and its position. The table index is round*NUM_SLOTS + slot.
- R13: cfg_err stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rounds | input | 2 | Rounds-per-cycle select |
| local_slot | input | SLOT_W | Slot index owned by this node |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | IDX_W | Table write index |
| tbl_wdata | input | ENTRY_W | Table entry {rx, at, addr, len} |
| tx_start | output | 1 | Transmit-start pulse |
| rx_start | output | 1 | Receive-start pulse |
| cmd_addr | output | ADDR_W | Buffer address of the frame |
| cmd_len | output | LEN_W | Frame length in bytes |
| cmd_round | output | RND_W | Round of the issued command |
| cmd_slot | output | SLOT_W | Slot of the issued command |
| global_time | output | GT_W | Free-running time count |
| tick | output | 1 | Periodic host tick pulse |
| cfg_err | output | 1 | Sticky schedule-consistency error |

## Verification
The bench sweeps every rounds-per-cycle setting over two full cycles and checks every cycle against an arithmetic model of the table. This separates a wrong round wrap, from a gap at the cycle boundary, from a wrong slot instant. The table mixes receive slots, a local transmit slot whose length walks from 0 up to 32, and a remote slot with no receive bit. Together these tell apart the owner rule, the receive rule and zero-length suppression. A final run plants an oversize length and an out-of-order instant. It checks that each bad entry is dropped, that the flag rises in the right cycle, and that later slots keep their timing.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    parameter int TIME_W  = 8;
    parameter int ADDR_W  = 10;
    parameter int LEN_W   = 6;
    parameter int MAX_LEN = 32;

    typedef struct packed {
        logic              rx;
        logic [TIME_W-1:0] at;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/tdma_table.sv
module tdma_table #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [IDX_W-1:0]             waddr,
    input  logic [tdma_pkg::ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]             raddr,
    output tdma_pkg::entry_t             rdata
);
    tdma_pkg::entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= tdma_pkg::entry_t'(wdata);
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tdma_tick.sv
module tdma_tick #(
    parameter int TICK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tk_t;

    tk_t tk_d, tk_q;

    always_comb begin
        tk_d      = tk_q;
        tk_d.tick = (tk_q.cnt == CNT_W'(TICK_DIV - 1));
        tk_d.cnt  = tk_d.tick ? '0 : tk_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    assign tick = tk_q.tick;

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tdma_sequencer.sv
module tdma_sequencer #(
    parameter int NUM_SLOTS  = 4,
    parameter int MAX_ROUNDS = 16,
    parameter int ROUND_LEN  = 16,
    parameter int TICK_DIV   = 8,
    parameter int GT_W       = 32,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int RND_W     = $clog2(MAX_ROUNDS),
    localparam int IDX_W     = SLOT_W + RND_W,
    localparam int RT_W      = $clog2(ROUND_LEN),
    localparam int ENTRY_W   = tdma_pkg::ENTRY_W,
    localparam int ADDR_W    = tdma_pkg::ADDR_W,
    localparam int LEN_W     = tdma_pkg::LEN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_rounds,
    input  logic [SLOT_W-1:0]  local_slot,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_waddr,
    input  logic [ENTRY_W-1:0] tbl_wdata,
    output logic               tx_start,
    output logic               rx_start,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [LEN_W-1:0]   cmd_len,
    output logic [RND_W-1:0]   cmd_round,
    output logic [SLOT_W-1:0]  cmd_slot,
    output logic [GT_W-1:0]    global_time,
    output logic               tick,
    output logic               cfg_err
);
    import tdma_pkg::*;

    typedef struct packed {
        logic [GT_W-1:0]   gtime;
        logic [RT_W-1:0]   rtime;
        logic [RND_W-1:0]  round;
        logic [SLOT_W-1:0] slot;
        logic              done;
        logic [TIME_W-1:0] prev_at;
        logic              tx;
        logic              rx;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [RND_W-1:0]  c_round;
        logic [SLOT_W-1:0] c_slot;
        logic              err;
    } st_t;

    st_t    st_d, st_q;
    entry_t cur;
    logic [5:0]       rcount;
    logic [RND_W-1:0] last_round;
    logic             bad_order, bad_len, at_hit, fire;

    tdma_table #(.DEPTH(MAX_ROUNDS * NUM_SLOTS), .IDX_W(IDX_W)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr ({st_q.round, st_q.slot}),
        .rdata (cur)
    );

    tdma_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    always_comb begin
        rcount = 6'd2 << cfg_rounds;
        if (rcount > 6'(MAX_ROUNDS)) rcount = 6'(MAX_ROUNDS);
        last_round = RND_W'(rcount - 6'd1);

        bad_order = !st_q.done && (st_q.slot != '0) && (cur.at <= st_q.prev_at);
        at_hit    = !st_q.done && !bad_order && (TIME_W'(st_q.rtime) == cur.at);
        bad_len   = at_hit && !cur.rx && (st_q.slot == local_slot)
                    && (cur.len > LEN_W'(MAX_LEN));

        st_d       = st_q;
        st_d.gtime = st_q.gtime + GT_W'(1);
        st_d.tx    = 1'b0;
        st_d.rx    = 1'b0;

        if (bad_order || bad_len) st_d.err = 1'b1;

        fire = 1'b0;
        if (at_hit) begin
            st_d.prev_at = cur.at;
            if (cur.rx) begin
                st_d.rx = 1'b1;
                fire    = 1'b1;
            end else if (st_q.slot == local_slot && cur.len != '0 && !bad_len) begin
                st_d.tx = 1'b1;
                fire    = 1'b1;
            end
        end
        if (fire) begin
            st_d.addr    = cur.addr;
            st_d.len     = cur.len;
            st_d.c_round = st_q.round;
            st_d.c_slot  = st_q.slot;
        end

        if (bad_order || at_hit) begin
            if (st_q.slot == SLOT_W'(NUM_SLOTS - 1)) st_d.done = 1'b1;
            else                                     st_d.slot = st_q.slot + SLOT_W'(1);
        end

        if (st_q.rtime == RT_W'(ROUND_LEN - 1)) begin
            st_d.rtime   = '0;
            st_d.slot    = '0;
            st_d.done    = 1'b0;
            st_d.prev_at = '0;
            st_d.round   = (st_q.round >= last_round) ? '0 : st_q.round + RND_W'(1);
        end else begin
            st_d.rtime = st_q.rtime + RT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_start    = st_q.tx;
    assign rx_start    = st_q.rx;
    assign cmd_addr    = st_q.addr;
    assign cmd_len     = st_q.len;
    assign cmd_round   = st_q.c_round;
    assign cmd_slot    = st_q.c_slot;
    assign global_time = st_q.gtime;
    assign cfg_err     = st_q.err;

    // R7
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_start && rx_start));

    // R8
    tx_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (cmd_slot == local_slot));

    // R9
    tx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (cmd_len != '0 && cmd_len <= LEN_W'(MAX_LEN)));

    // R13
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R2
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (global_time == $past(global_time) + GT_W'(1)));

    // R5
    round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start || rx_start) |-> (cmd_round <= last_round));
endmodule

// File: tb/tdma_sequencer_bench.sv
module tdma_sequencer_bench;
    localparam int NS = 4;
    localparam int MR = 16;
    localparam int RL = 16;
    localparam int TD = 8;
    localparam int LOCAL = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_rounds = '0;
    logic [1:0]  local_slot = 2'(LOCAL);
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_waddr = '0;
    logic [24:0] tbl_wdata = '0;
    logic        tx_start, rx_start, tick, cfg_err;
    logic [9:0]  cmd_addr;
    logic [5:0]  cmd_len;
    logic [3:0]  cmd_round;
    logic [1:0]  cmd_slot;
    logic [31:0] global_time;

    always #4 clk = ~clk;

    tdma_sequencer u_tdma_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_rounds(cfg_rounds), .local_slot(local_slot),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .tx_start(tx_start), .rx_start(rx_start), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_round(cmd_round), .cmd_slot(cmd_slot),
        .global_time(global_time), .tick(tick), .cfg_err(cfg_err)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int m_at[64], m_rx[64], m_addr[64], m_len[64];

    task automatic chk(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic build_table(bit errmode);
        for (int r = 0; r < MR; r++) begin
            for (int s = 0; s < NS; s++) begin
                int idx = r * NS + s;
                m_at[idx]   = (s == 0) ? 0 : (s == 1) ? 4 : (s == 2) ? 8 : 15;
                m_rx[idx]   = (s == 0 || s == 3) ? 1 : (s == 2) ? (r % 2) : 0;
                m_addr[idx] = (idx * 3 + 5) % 1024;
                m_len[idx]  = (s == LOCAL) ? (r * 5) % 33 : (r + s * 7) % 33;
            end
        end
        if (errmode) begin
            m_len[1] = 40;      // R10: oversize local frame in round 0
            m_at[NS + 2] = 2;   // R11: instant before slot 1 in round 1
        end
    endtask

    task automatic load_and_reset(int cfg);
        rst_n = 1'b0;
        cfg_rounds = 2'(cfg);
        for (int idx = 0; idx < MR * NS; idx++) begin
            @(negedge clk);
            tbl_we    = 1'b1;
            tbl_waddr = 6'(idx);
            tbl_wdata = {1'(m_rx[idx]), 8'(m_at[idx]), 10'(m_addr[idx]), 6'(m_len[idx])};
        end
        @(negedge clk);
        tbl_we = 1'b0;
        // R1: reset state
        chk(!tx_start && !rx_start && !tick && !cfg_err, "R1 flags", 
            {tx_start, rx_start, tick, cfg_err}, 0);
        chk(global_time == 0 && cmd_addr == 0 && cmd_len == 0 && cmd_round == 0
            && cmd_slot == 0, "R1 fields", global_time, 0);
        rst_n = 1'b1;
    endtask

    task automatic run(int cfg, bit errmode, int ncyc);
        int nr = 2 << cfg;
        int last_c = -10, last_r = -1, last_s = -1;
        for (int c = 1; c <= ncyc; c++) begin
            int p, q, r, t, fire, prev, idx;
            bit etx, erx;
            string tlab, rlab;
            @(posedge clk);
            #2;
            p = c - 1;
            q = p % (nr * RL);
            r = q / RL;
            t = q % RL;
            fire = -1;
            prev = -1;
            for (int s = 0; s < NS; s++) begin
                int a = m_at[r * NS + s];
                if (s == 0 || a > prev) begin
                    prev = a;
                    if (a == t) fire = s;
                end
            end
            idx = r * NS + fire;
            etx = 0;
            erx = 0;
            tlab = "R8";
            rlab = (errmode && r == 1 && t == 2) ? "R11" : "R7";
            if (fire >= 0) begin
                erx = (m_rx[idx] != 0);
                if (!erx && fire == LOCAL) begin
                    if (m_len[idx] == 0)      tlab = "R9";
                    else if (m_len[idx] > 32) tlab = "R10";
                    etx = (m_len[idx] != 0 && m_len[idx] <= 32);
                end
            end
            chk(global_time == 32'(c), "R2 time", global_time, c);
            chk(tick == (c % TD == 0), "R3 tick", tick, (c % TD == 0));
            chk(tx_start == etx, tlab, tx_start, etx);
            chk(rx_start == erx, rlab, rx_start, erx);
            if (etx || erx) begin
                chk(cmd_addr == 10'(m_addr[idx]) && cmd_len == 6'(m_len[idx]),
                    "R12 fields", {cmd_addr, cmd_len}, {m_addr[idx], m_len[idx]});
                chk(cmd_slot == 2'(fire), "R4 slot", cmd_slot, fire);
                chk(cmd_round == 4'(r), "R5 round", cmd_round, r);
                if (r == 0 && fire == 0 && c > 1)
                    chk(last_c == c - 1 && last_r == nr - 1 && last_s == NS - 1,
                        "R6 wrap", last_c, c - 1);
                last_c = c;
                last_r = r;
                last_s = fire;
            end
            if (errmode)
                chk(cfg_err == (c >= 5), (c < 5) ? "R10 flag" : "R13 flag", cfg_err, (c >= 5));
            else
                chk(cfg_err == 1'b0, "R11 noflag", cfg_err, 0);
        end
    endtask

    initial begin
        for (int cfg = 0; cfg < 4; cfg++) begin
            build_table(1'b0);
            load_and_reset(cfg);
            run(cfg, 1'b0, 2 * (2 << cfg) * RL);
        end
        build_table(1'b1);
        load_and_reset(0);
        run(0, 1'b1, 4 * RL);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule